// File: doc/BRIEF.md
# Byte-Wide I2C Bus Master With Register Control

This block is a memory-mapped I2C master. Software sees six byte-wide registers: a clock divider, a glitch-filter setting, a control byte, a status byte, a data byte and an own-address slot that always reads zero. Bus conditions follow edges of the master-start control bit. Setting it issues a START. Clearing it issues a STOP. Writing the repeat bit while it stays set issues a repeated START. The block drives SCL and SDA as open-drain outputs, so each output only says when the line is pulled low. It samples SDA for acknowledges.

After each START, the first data-register write is sent as the address byte. Further writes are sent only while the transmit-direction bit is set. Receiving is pipelined. A data-register read returns the byte buffered by the read before it and, when the bus is addressed and in receive direction, launches the next receive. A single level interrupt combines the interrupt-enable bit with the interrupt flag, which every completed byte sets. Slave operation and arbitration are not built. The arbitration-lost flag is only a software-writable status bit.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, status reads 0x81, control, divider and filter read 0x00, `irq` is low and neither bus line is pulled low.
- R2: Register offsets are divider 0x04, control 0x08, status 0x0C, data 0x10 and filter 0x14. Offset 0x00 reads 0x00 and ignores writes. Every other offset reads 0xFF.
- R3: The divider and filter registers keep only their low 6 bits (writing 0xFF reads back 0x3F).
- R4: Control bit positions are enable 7, interrupt-enable 6, master-start 5, transmit-direction 4, transmit-ack 3 and repeat 2. Bits 2 and 1 always read as 0.
- R5: Status bits are transfer-complete 7, bus-busy 5, arbitration-lost 4, interrupt-flag 1 and received-ack 0 (bits 6, 3 and 2 read 0). A status write changes only bits 4 and 1 (mask 0x12).
- R6: `irq` equals control bit 6 AND status bit 1. It follows status writes and byte completions.
- R7: While transfer-complete is 1 and a control write sets enable: master-start 0→1 issues START and sets bus-busy, 1→0 issues STOP and clears bus-busy, and repeat with master-start held at 1 issues a repeated START. A control write with enable clear issues no condition.
- R8: The first data write after a START or repeated START is sent as the address byte, with bit 0 as the direction. Later writes are sent only with transmit-direction set. Writes while receiving, disabled or not bus-busy put nothing on the bus.
- R9: Transfer-complete reads 0 while a condition or byte is on the bus and 1 otherwise. Each completed byte sets the interrupt flag and loads received-ack with the SDA level of the ninth clock (0 = acknowledged).
- R10: A data read returns the buffered byte (0xFF after reset). When enabled, bus-busy, addressed and not transmitting, the read also receives the next byte into the buffer. Otherwise the buffer becomes 0xFF.
- R11: On a received byte the master drives the ninth bit from transmit-ack: 0 pulls SDA low (ACK) and 1 leaves it high (NACK).
- R12: Each SCL half-period lasts (divider+1)×4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data offset has a side effect) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench goes after the one-read lag of the receive path. A design that returned the fresh byte, or left a stale byte in the buffer after STOP, would show the wrong value on the first read of a burst or on the reads after STOP. It writes all ones to status and to control with enable clear. A design with a loose write mask would turn on read-only flags, and one that decoded conditions without enable would put a START on the bus. An open-drain slave model checks the address, data, master ACK/NACK and START/STOP edges on the lines. A timed SCL high phase at a nonzero divider catches a wrong half-period formula.

// File: rtl/i2ch_pkg.sv
`timescale 1ns/1ps
package i2ch_pkg;
  // register offsets (byte addresses)
  localparam logic [7:0] OFS_OWN = 8'h00;
  localparam logic [7:0] OFS_DIV = 8'h04;
  localparam logic [7:0] OFS_CTL = 8'h08;
  localparam logic [7:0] OFS_STA = 8'h0C;
  localparam logic [7:0] OFS_DAT = 8'h10;
  localparam logic [7:0] OFS_FLT = 8'h14;

  // control bit positions
  localparam int CB_EN   = 7;
  localparam int CB_IEN  = 6;
  localparam int CB_MSTA = 5;
  localparam int CB_TX   = 4;
  localparam int CB_TXAK = 3;
  localparam int CB_RSTA = 2;
  localparam logic [7:0] CTL_KEEP = 8'hF9;

  // status bit positions
  localparam int SB_MAL = 4;
  localparam int SB_MIF = 1;

  typedef enum logic [2:0] {
    CMD_START, CMD_RSTART, CMD_STOP, CMD_TX, CMD_RX
  } cmd_e;

  // SCL half-period in system clocks
  function automatic int half_period(int div, int scale);
    return (div + 1) * scale;
  endfunction
endpackage

// File: rtl/i2ch_tick.sv
`timescale 1ns/1ps
module i2ch_tick #(
  parameter int DIV_W = 6,
  parameter int SCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import i2ch_pkg::*;
  localparam int CNT_W = $clog2((2 ** DIV_W) * SCALE) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_period(int'(div), SCALE) - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R12
endmodule

// File: rtl/i2ch_engine.sv
`timescale 1ns/1ps
module i2ch_engine #(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  i2ch_pkg::cmd_e         cmd_kind,
  input  logic [DATA_W-1:0]      cmd_byte,
  input  logic                   cmd_ack,
  input  logic                   tick,
  input  logic                   sda_in,
  output logic                   busy,
  output logic                   done_byte,
  output logic                   done_rx,
  output logic [DATA_W-1:0]      rx_byte,
  output logic                   ack_seen,
  output logic                   scl_low,
  output logic                   sda_low
);
  import i2ch_pkg::*;
  localparam int LAST_BYTE_PH = 2 * (DATA_W + 1);
  localparam int PH_W = $clog2(LAST_BYTE_PH + 1);

  cmd_e              kind_q;
  logic [PH_W-1:0]   phase_q;
  logic [DATA_W-1:0] txb_q;
  logic              ack_q;
  logic              done_q;
  logic              is_byte;
  logic              at_last;
  logic              accept;
  int                bit_now;

  // {scl_low, sda_low} for a given step of a given action
  function automatic logic [1:0] drive_of(cmd_e k, logic [PH_W-1:0] p,
                                          logic [DATA_W-1:0] t, logic a);
    int   b;
    logic level;
    case (k)
      CMD_START:  return (p == 0) ? 2'b01 : 2'b11;
      CMD_RSTART: case (int'(p))
                    0:       return 2'b10;
                    1:       return 2'b00;
                    2:       return 2'b01;
                    default: return 2'b11;
                  endcase
      CMD_STOP:   case (int'(p))
                    0:       return 2'b11;
                    1:       return 2'b01;
                    default: return 2'b00;
                  endcase
      default: begin
        if (int'(p) == LAST_BYTE_PH) return 2'b10;
        b = int'(p) >> 1;
        if (b < DATA_W) level = (k == CMD_TX) ? t[DATA_W-1-b] : 1'b1;
        else            level = (k == CMD_TX) ? 1'b1 : a;
        return {~p[0], ~level};
      end
    endcase
  endfunction

  function automatic int last_of(cmd_e k);
    case (k)
      CMD_START:  return 1;
      CMD_RSTART: return 3;
      CMD_STOP:   return 2;
      default:    return LAST_BYTE_PH;
    endcase
  endfunction

  assign is_byte   = (kind_q == CMD_TX) || (kind_q == CMD_RX);
  assign at_last   = (int'(phase_q) == last_of(kind_q));
  assign accept    = cmd_valid && !busy;
  assign bit_now   = int'(phase_q) >> 1;
  assign done_byte = done_q && is_byte;
  assign done_rx   = done_q && (kind_q == CMD_RX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= CMD_STOP;
      phase_q <= '0;
      txb_q   <= '0;
      ack_q   <= 1'b0;
      rx_byte <= '0;
      ack_seen <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        kind_q  <= cmd_kind;
        phase_q <= '0;
        txb_q   <= cmd_byte;
        ack_q   <= cmd_ack;
        {scl_low, sda_low} <= drive_of(cmd_kind, '0, cmd_byte, cmd_ack);
      end else if (busy && tick) begin
        if (is_byte && phase_q[0]) begin
          if (bit_now < DATA_W) rx_byte  <= {rx_byte[DATA_W-2:0], sda_in};
          else                  ack_seen <= sda_in;
        end
        if (at_last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
          {scl_low, sda_low} <= drive_of(kind_q, phase_q + 1'b1, txb_q, ack_q);
        end
      end
    end
  end

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick || accept) |=> ($stable(scl_low) && $stable(sda_low))); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R9
endmodule

// File: rtl/i2c_host_ctrl.sv
`timescale 1ns/1ps
module i2c_host_ctrl #(
  parameter int AW         = 5,
  parameter int DIV_W      = 6,
  parameter int FLT_W      = 6,
  parameter int HALF_SCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic          sda_in
);
  import i2ch_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [FLT_W-1:0] flt_q;
  logic [7:0]       ctrl_q;
  logic             mbb_q, mal_q, mif_q, rxak_q, addr_pend_q;
  logic [7:0]       dbuf_q;
  logic [7:0]       a8;
  logic [7:0]       status;

  // named events
  logic wr_ctl, wr_sta, wr_dat, rd_dat;
  logic ev_start, ev_stop, ev_rstart, ev_addr, ev_txd, ev_rx, rd_flush;
  logic en_busy, cmd_valid;
  cmd_e cmd_kind;

  logic       eng_busy, tick, done_byte, done_rx, ack_seen;
  logic [7:0] rx_byte;

  assign a8     = 8'(reg_addr);
  assign wr_ctl = reg_wr && (a8 == OFS_CTL);
  assign wr_sta = reg_wr && (a8 == OFS_STA);
  assign wr_dat = reg_wr && (a8 == OFS_DAT);
  assign rd_dat = reg_rd && (a8 == OFS_DAT);

  assign ev_start  = wr_ctl && !eng_busy && reg_wdata[CB_EN] &&
                     !ctrl_q[CB_MSTA] && reg_wdata[CB_MSTA];
  assign ev_stop   = wr_ctl && !eng_busy && reg_wdata[CB_EN] &&
                     ctrl_q[CB_MSTA] && !reg_wdata[CB_MSTA];
  assign ev_rstart = wr_ctl && !eng_busy && reg_wdata[CB_EN] &&
                     ctrl_q[CB_MSTA] && reg_wdata[CB_MSTA] && reg_wdata[CB_RSTA];

  assign en_busy  = ctrl_q[CB_EN] && mbb_q && !eng_busy;
  assign ev_addr  = wr_dat && en_busy && addr_pend_q;
  assign ev_txd   = wr_dat && en_busy && !addr_pend_q && ctrl_q[CB_TX];
  assign ev_rx    = rd_dat && en_busy && !addr_pend_q && !ctrl_q[CB_TX];
  assign rd_flush = rd_dat && !ev_rx;

  assign cmd_valid = ev_start || ev_stop || ev_rstart || ev_addr || ev_txd || ev_rx;

  always_comb begin
    if (ev_start)                cmd_kind = CMD_START;
    else if (ev_stop)            cmd_kind = CMD_STOP;
    else if (ev_rstart)          cmd_kind = CMD_RSTART;
    else if (ev_addr || ev_txd)  cmd_kind = CMD_TX;
    else                         cmd_kind = CMD_RX;
  end

  i2ch_tick #(.DIV_W(DIV_W), .SCALE(HALF_SCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div_q), .tick(tick)
  );

  i2ch_engine #(.DATA_W(8)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_byte(reg_wdata),
    .cmd_ack(ctrl_q[CB_TXAK]), .tick(tick), .sda_in(sda_in),
    .busy(eng_busy), .done_byte(done_byte), .done_rx(done_rx),
    .rx_byte(rx_byte), .ack_seen(ack_seen),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= '0;
      flt_q       <= '0;
      ctrl_q      <= '0;
      mbb_q       <= 1'b0;
      mal_q       <= 1'b0;
      mif_q       <= 1'b0;
      rxak_q      <= 1'b1;
      addr_pend_q <= 1'b0;
      dbuf_q      <= 8'hFF;
    end else begin
      if (reg_wr && a8 == OFS_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_wr && a8 == OFS_FLT) flt_q <= reg_wdata[FLT_W-1:0];
      if (wr_ctl) ctrl_q <= reg_wdata & CTL_KEEP;
      if (ev_start || ev_rstart) mbb_q <= 1'b1;
      else if (ev_stop)          mbb_q <= 1'b0;
      if (ev_start || ev_rstart) addr_pend_q <= 1'b1;
      else if (ev_addr)          addr_pend_q <= 1'b0;
      if (wr_sta) mal_q <= reg_wdata[SB_MAL];
      if (done_byte)   mif_q <= 1'b1;
      else if (wr_sta) mif_q <= reg_wdata[SB_MIF];
      if (done_byte) rxak_q <= ack_seen;
      if (done_rx)       dbuf_q <= rx_byte;
      else if (rd_flush) dbuf_q <= 8'hFF;
    end
  end

  assign status = {!eng_busy, 1'b0, mbb_q, mal_q, 2'b00, mif_q, rxak_q};
  assign irq    = ctrl_q[CB_IEN] & mif_q;

  always_comb begin
    case (a8)
      OFS_OWN: reg_rdata = 8'h00;
      OFS_DIV: reg_rdata = 8'(div_q);
      OFS_CTL: reg_rdata = ctrl_q;
      OFS_STA: reg_rdata = status;
      OFS_DAT: reg_rdata = dbuf_q;
      OFS_FLT: reg_rdata = 8'(flt_q);
      default: reg_rdata = 8'hFF;
    endcase
  end

  AST_BYTE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_byte |=> mif_q); // R9
  AST_CMD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !eng_busy); // R7
  AST_DISABLED_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !ctrl_q[CB_EN] && !eng_busy) |=> !eng_busy); // R8
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sta && !done_byte) |=> ((rxak_q == $past(rxak_q)) && (mbb_q == $past(mbb_q)))); // R5
endmodule

// File: tb/i2c_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_host_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, scl_drv, sda_drv;
  logic       scl_line, sda_line;
  logic       slv_drv = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_drv;
  assign sda_line = ~(sda_drv | slv_drv);

  i2c_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_drive_low(scl_drv), .sda_drive_low(sda_drv),
    .sda_in(sda_line)
  );

  // ---------------- slave model (7-bit address 0x50) ----------------
  localparam logic [6:0] SLV_ADDR = 7'h50;
  int         n_start = 0, n_stop = 0;
  logic       slv_act = 1'b0, slv_skip = 1'b0, slv_rd = 1'b0, slv_match = 1'b0;
  logic       slv_mack = 1'b0;
  logic [7:0] slv_sh = '0, slv_txb = '0, addr_log = '0;
  int         slv_bit = 0, slv_idx = 0;
  logic [7:0] wr_log [8];
  int         wr_n = 0, rd_n = 0;
  logic       mack_log [8];
  int         mk_n = 0;

  function automatic logic [7:0] slave_byte(int k);
    return 8'hA5 + 8'(k * 8'h13);
  endfunction

  always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin
    slv_act = 1'b1; slv_bit = 0; slv_idx = 0; slv_sh = '0;
    slv_skip = 1'b1; slv_rd = 1'b0; slv_drv = 1'b0; n_start++;
  end

  always @(posedge sda_line) if (rst_n && scl_line === 1'b1) begin
    slv_act = 1'b0; slv_drv = 1'b0; n_stop++;
  end

  always @(posedge scl_line) if (slv_act) begin
    if (!(slv_rd && slv_idx > 0) && slv_bit < 8) slv_sh = {slv_sh[6:0], sda_line};
    if (slv_rd && slv_idx > 0 && slv_bit == 8) begin
      slv_mack = sda_line;
      if (mk_n < 8) mack_log[mk_n] = sda_line;
      mk_n++;
    end
  end

  always @(negedge scl_line) if (slv_act) begin
    if (slv_skip) slv_skip = 1'b0;
    else if (slv_bit < 8) begin
      slv_bit++;
      if (slv_bit == 8) begin
        if (!(slv_rd && slv_idx > 0)) begin
          if (slv_idx == 0) begin
            slv_match = (slv_sh[7:1] == SLV_ADDR);
            slv_rd = slv_sh[0] && slv_match;
            addr_log = slv_sh;
            slv_drv = slv_match;
          end else begin
            if (wr_n < 8) wr_log[wr_n] = slv_sh;
            wr_n++;
            slv_drv = 1'b1;
          end
        end else slv_drv = 1'b0;
      end else if (slv_rd && slv_idx > 0) slv_drv = ~slv_txb[7 - slv_bit];
    end else begin
      slv_bit = 0;
      if (slv_rd && (slv_idx == 0 || slv_mack == 1'b0)) begin
        slv_txb = slave_byte(rd_n); rd_n++; slv_drv = ~slv_txb[7];
      end else slv_drv = 1'b0;
      slv_idx++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic irq_v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    d = reg_rdata; irq_v = irq;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d; logic i;
    rd(a, d, i);
    chk(req, 32'(d), 32'(exp));
  endtask

  task automatic wait_idle();
    logic [7:0] d; logic i;
    for (int k = 0; k < 4000; k++) begin
      rd(5'h0C, d, i);
      if (d[7]) break;
    end
  endtask

  // {op(1=write), addr, wdata, expected read, expected irq}
  localparam int NV = 21;
  localparam logic [22:0] VECS [NV] = '{
    {1'b1, 5'h04, 8'hFF, 8'h00, 1'b0},
    {1'b0, 5'h04, 8'h00, 8'h3F, 1'b0},  // R3
    {1'b1, 5'h14, 8'hC5, 8'h00, 1'b0},
    {1'b0, 5'h14, 8'h00, 8'h05, 1'b0},  // R3
    {1'b1, 5'h00, 8'h77, 8'h00, 1'b0},
    {1'b0, 5'h00, 8'h00, 8'h00, 1'b0},  // R2
    {1'b0, 5'h18, 8'h00, 8'hFF, 1'b0},  // R2
    {1'b0, 5'h03, 8'h00, 8'hFF, 1'b0},  // R2
    {1'b0, 5'h1F, 8'h00, 8'hFF, 1'b0},  // R2
    {1'b1, 5'h08, 8'h7F, 8'h00, 1'b0},
    {1'b0, 5'h08, 8'h00, 8'h79, 1'b0},  // R4
    {1'b1, 5'h0C, 8'hFF, 8'h00, 1'b0},
    {1'b0, 5'h0C, 8'h00, 8'h93, 1'b1},  // R5 R6
    {1'b1, 5'h0C, 8'h00, 8'h00, 1'b0},
    {1'b0, 5'h0C, 8'h00, 8'h81, 1'b0},  // R5 R6
    {1'b1, 5'h10, 8'h55, 8'h00, 1'b0},
    {1'b0, 5'h0C, 8'h00, 8'h81, 1'b0},  // R8 disabled write
    {1'b1, 5'h08, 8'h00, 8'h00, 1'b0},
    {1'b0, 5'h08, 8'h00, 8'h00, 1'b0},  // R4
    {1'b1, 5'h04, 8'h00, 8'h00, 1'b0},
    {1'b0, 5'h04, 8'h00, 8'h00, 1'b0}   // R3
  };

  bit finished = 1'b0;

  initial begin
    #900000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic iv;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(5'h0C, d, iv);
    chk("R1 status", 32'(d), 32'h81);
    chk("R1 irq", 32'(iv), 32'h0);
    rd_chk("R1 control", 5'h08, 8'h00);
    rd_chk("R1 divider", 5'h04, 8'h00);
    rd_chk("R1 filter", 5'h14, 8'h00);
    chk("R1 lines", 32'({scl_line, sda_line}), 32'h3);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      if (VECS[v][22]) wr(VECS[v][21:17], VECS[v][16:9]);
      else begin
        rd(VECS[v][21:17], d, iv);
        chk($sformatf("R2-5 vector %0d data", v), 32'(d), 32'(VECS[v][8:1]));
        chk($sformatf("R6 vector %0d irq", v), 32'(iv), 32'(VECS[v][0]));
      end
    end

    // R7: no condition while disabled
    wr(5'h08, 8'h20);
    repeat (40) @(negedge clk);
    chk("R7 disabled no start", 32'(n_start), 32'd0);
    rd_chk("R7 disabled status", 5'h0C, 8'h81);
    wr(5'h08, 8'h00);

    // write transfer
    wr(5'h08, 8'hD0);
    wr(5'h08, 8'hF0);
    wait_idle();
    chk("R7 start seen", 32'(n_start), 32'd1);
    rd_chk("R7 busy after start", 5'h0C, 8'hA1);
    wr(5'h10, 8'hA0);
    rd_chk("R9 complete low while shifting", 5'h0C, 8'h21);
    wait_idle();
    rd(5'h0C, d, iv);
    chk("R9 status after address", 32'(d), 32'hA2);
    chk("R6 irq after byte", 32'(iv), 32'h1);
    chk("R8 address byte", 32'(addr_log), 32'hA0);
    wr(5'h0C, 8'h00);
    rd(5'h0C, d, iv);
    chk("R6 irq cleared", 32'(iv), 32'h0);
    wr(5'h10, 8'h3C); wait_idle();
    wr(5'h10, 8'hC3); wait_idle();
    chk("R8 data count", 32'(wr_n), 32'd2);
    chk("R8 data 0", 32'(wr_log[0]), 32'h3C);
    chk("R8 data 1", 32'(wr_log[1]), 32'hC3);
    wr(5'h08, 8'hE0);
    wr(5'h10, 8'h99);
    rd_chk("R8 receive-dir write idle", 5'h0C, 8'hA2);
    repeat (100) @(negedge clk);
    chk("R8 receive-dir write ignored", 32'(wr_n), 32'd2);

    // repeated start, then read
    wr(5'h08, 8'hF4);
    wait_idle();
    chk("R7 repeated start", 32'(n_start), 32'd2);
    rd_chk("R4 repeat bit reads 0", 5'h08, 8'hF0);
    wr(5'h10, 8'hA1); wait_idle();
    wr(5'h08, 8'hE0);
    rd_chk("R10 first read old buffer", 5'h10, 8'hFF); wait_idle();
    rd_chk("R10 read byte0", 5'h10, slave_byte(0)); wait_idle();
    wr(5'h08, 8'hE8);
    rd_chk("R10 read byte1", 5'h10, slave_byte(1)); wait_idle();
    rd(5'h0C, d, iv);
    chk("R11 nack sampled", 32'(d[0]), 32'h1);
    chk("R11 master acks", 32'(mk_n), 32'd3);
    chk("R11 ack byte0", 32'(mack_log[0]), 32'h0);
    chk("R11 ack byte1", 32'(mack_log[1]), 32'h0);
    chk("R11 nack byte2", 32'(mack_log[2]), 32'h1);
    wr(5'h08, 8'hC8);
    wait_idle();
    chk("R7 stop seen", 32'(n_stop), 32'd1);
    rd_chk("R7 busy cleared", 5'h0C, 8'h83);
    chk("R7 lines released", 32'({scl_line, sda_line}), 32'h3);
    rd_chk("R10 last byte after stop", 5'h10, slave_byte(2));
    rd_chk("R10 flushed", 5'h10, 8'hFF);
    wr(5'h10, 8'h55);
    rd_chk("R8 not-busy write idle", 5'h0C, 8'h83);
    repeat (100) @(negedge clk);
    chk("R8 not-busy write ignored", 32'(wr_n), 32'd2);

    // unanswered address
    wr(5'h08, 8'h90);
    wr(5'h08, 8'hB0); wait_idle();
    wr(5'h10, 8'h84); wait_idle();
    rd_chk("R9 no ack", 5'h0C, 8'hA3);
    wr(5'h08, 8'h90); wait_idle();
    chk("R7 second stop", 32'(n_stop), 32'd2);

    // R12 half-period with divider 2
    wr(5'h04, 8'h02);
    wr(5'h08, 8'hB0); wait_idle();
    wr(5'h10, 8'hA0);
    @(posedge scl_line);
    begin
      int n;
      n = 0;
      do begin
        @(posedge clk); n++; #1;
      end while (scl_line === 1'b1 && n < 1000);
      chk("R12 scl high cycles", 32'(n), 32'd12);
    end
    wait_idle();
    wr(5'h08, 8'h90); wait_idle();
    chk("R12 stop at slow rate", 32'(n_stop), 32'd3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule